// File: doc/BRIEF.md
# Single-Line Configurable Interrupt Controller

This block watches one asynchronous external interrupt line, such as a non-maskable interrupt pin, and turns it into a single interrupt request toward the processor's main interrupt controller. The line is brought into the clock domain through a synchronizer. A detector then recognises either a level or an edge of the selected polarity. A hit sets a pending flag, and the pending flag, gated by an enable bit, drives the registered output.

Software reaches the block through a simple 32-bit register port: a write strobe with address and write data, and a read data bus that follows the address combinationally. There are three registers. The trigger-mode register selects one of four trigger modes. The pending register is cleared by writing a one to its bit 0. The enable register masks the output, and a build-time variant parameter places it at one of two offsets. Only interrupt source number 0 exists.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, irq_out is 0, pending reads 0, enable reads 0, and the trigger-mode register reads 3 (rising edge).
- R2: The trigger-mode register sits at offset 0x0. Bits [1:0] hold the mode code: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. A write stores the code and a read returns it.
- R3: In the edge modes (codes 1 and 3), pending is set when the synchronized input makes a transition to the active value. Pending then stays set, whatever the input does, until software acknowledges it.
- R4: In the level modes (codes 0 and 2), pending is set on every cycle in which the synchronized input holds its active value. Pending therefore reads 1 again right after an acknowledge while the level persists.
- R5: The pending register sits at offset 0x4, with the flag in bit 0. It reads 0 when nothing is pending. Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R6: The enable register is bit 0 at offset 0x8 when ENA_VARIANT=0 and at offset 0x34 when ENA_VARIANT=1. On each clock, irq_out takes the value (pending AND enable) from the previous cycle. Clearing enable masks irq_out but does not clear pending.
- R7: When a new hit and an acknowledge write occur in the same cycle, the hit wins and pending stays 1.
- R8: Reads of unmapped offsets return 0, and writes to them change no register. This includes the enable offset of the variant that is not selected. Reserved register bits ignore writes and read as 0.
- R9: A change of irq_in that is set up before clock edge k causes a hit that sets pending at edge k+2, where it becomes visible on a read. irq_out follows at edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 1 | Asynchronous external interrupt line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_out | output | 1 | Interrupt request to the main interrupt controller |

## Verification
The assertions check, on every cycle, the rules that hold locally in time. A hit sets pending on the next cycle, and a hit that coincides with an acknowledge still leaves pending set. An acknowledge with no hit clears pending, and pending holds when there is no acknowledge. irq_out follows pending AND enable from the previous cycle, and reserved read bits stay zero. Other behaviour can only be shown by the bench's scenarios: the three-edge latency from the pin, the difference between edge and level modes once the input returns to its inactive value, the decoding of the variant's enable offset against the unused one, and the race between a late edge and an acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_EDGE_FAL = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_EDGE_RIS = 2'd3
  } trig_e;

  localparam int OFF_MODE     = 'h00;
  localparam int OFF_PEND     = 'h04;
  localparam int OFF_ENA_V0   = 'h08;
  localparam int OFF_ENA_V1   = 'h34;
  localparam trig_e MODE_RST  = TRIG_EDGE_RIS;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl,
  input  trig_e mode,
  output logic  hit
);
  logic prev_q;
  logic active;
  logic is_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    active  = mode[1] ? lvl : ~lvl;
    is_edge = mode[0];
    hit     = active & (~is_edge | (lvl ^ prev_q));
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter bit ENA_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hit,
  output trig_e             mode,
  output logic              pend,
  output logic              ena,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENA  = ENA_VARIANT ? ADDR_W'(OFF_ENA_V1)
                                                     : ADDR_W'(OFF_ENA_V0);

  trig_e mode_q, mode_d;
  logic  pend_q, pend_d;
  logic  ena_q,  ena_d;
  logic  out_q,  out_d;
  logic  mode_we, ena_we, ack;
  logic  unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:2];

  always_comb begin
    mode_we = bus_wr && (bus_addr == A_MODE);
    ena_we  = bus_wr && (bus_addr == A_ENA);
    ack     = bus_wr && (bus_addr == A_PEND) && bus_wdata[0];

    mode_d = mode_we ? trig_e'(bus_wdata[1:0]) : mode_q;
    ena_d  = ena_we  ? bus_wdata[0] : ena_q;
    if (hit)      pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
    else          pend_d = pend_q;
    out_d = pend_q & ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ena_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ena_q  <= ena_d;
      pend_q <= pend_d;
      out_q  <= out_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE)      bus_rdata[1:0] = mode_q;
    else if (bus_addr == A_PEND) bus_rdata[0]   = pend_q;
    else if (bus_addr == A_ENA)  bus_rdata[0]   = ena_q;
  end

  assign mode    = mode_q;
  assign pend    = pend_q;
  assign ena     = ena_q;
  assign irq_out = out_q;
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit ENA_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic  lvl_sync;
  logic  hit;
  trig_e mode;
  logic  pend_q;
  logic  en_q;

  irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_in), .q_sync(lvl_sync)
  );

  irqc_detect u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .mode(mode), .hit(hit)
  );

  irqc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENA_VARIANT(ENA_VARIANT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit),
    .mode(mode), .pend(pend_q), .ena(en_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              pend,
  input logic              en,
  input logic              hit
);
  logic ack;
  assign ack = bus_wr && (bus_addr == ADDR_W'(4)) && bus_wdata[0];

  a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);

  a_r3_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !pend);

  a_r7_hit_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> pend);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_out);

  a_r6_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en) |=> irq_out);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:2] == '0);
endmodule

bind irq_line_ctrl irqc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .pend(pend_q), .en(en_q), .hit(hit)
);

// File: tb/sim_irq_line_ctrl.sv
`timescale 1ns/1ps
module sim_irq_line_ctrl;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_MODE = 8'h00, A_PEND = 8'h04, A_ENA = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  irq_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference state built from the requirements
  logic       m_s1, m_s2, m_prev, m_pend, m_en, m_out;
  logic [1:0] m_mode;

  function automatic logic f_hit(logic [1:0] md, logic cur, logic prv);
    logic act;
    act = md[1] ? cur : ~cur;
    if (md[0]) return act && (cur != prv);
    return act;
  endfunction

  function automatic logic [31:0] f_rd(logic [7:0] a);
    if (a == A_MODE) return {30'd0, m_mode};
    if (a == A_PEND) return {31'd0, m_pend};
    if (a == A_ENA)  return {31'd0, m_en};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_pend <= 0;
      m_en <= 0; m_out <= 0; m_mode <= 2'd3;
    end else begin
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_out <= m_pend & m_en;
      if (f_hit(m_mode, m_s2, m_prev)) m_pend <= 1'b1;
      else if (bus_wr && bus_addr == A_PEND && bus_wdata[0]) m_pend <= 1'b0;
      if (bus_wr && bus_addr == A_MODE) m_mode <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_ENA)  m_en <= bus_wdata[0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(A_MODE, rv); chk("R1 mode", rv, 32'd3);
    rd(A_PEND, rv); chk("R1 pend", rv, 32'd0);
    rd(A_ENA, rv);  chk("R1 ena", rv, 32'd0);

    // R2 + R8 reserved bits
    wr(A_MODE, 32'hFFFF_FFF1);
    rd(A_MODE, rv); chk("R2/R8 mode readback", rv, 32'd1);
    wr(A_MODE, 32'd3);
    rd(A_MODE, rv); chk("R2 mode rising", rv, 32'd3);

    // R9 latency and R3 rising edge hold
    wr(A_ENA, 32'd1);
    wr(A_PEND, 32'd1);
    irq_in = 1'b1;            // before edge k
    tick(2);                  // edges k, k+1
    rd(A_PEND, rv); chk("R9 pend not yet", rv, 32'd0);
    tick();                   // edge k+2
    rd(A_PEND, rv); chk("R9 pend at k+2", rv, 32'd1);
    chk("R9 irq_out not yet", {31'd0, irq_out}, 32'd0);
    tick();
    chk("R9 irq_out at k+3", {31'd0, irq_out}, 32'd1);
    irq_in = 1'b0; tick(5);
    rd(A_PEND, rv); chk("R3 pend held after input drop", rv, 32'd1);

    // R5 write 0 ignored, write 1 clears
    wr(A_PEND, 32'hFFFF_FFFE);
    rd(A_PEND, rv); chk("R5 write0 no effect", rv, 32'd1);
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R5 ack clears", rv, 32'd0);
    tick();
    chk("R6 irq_out drops", {31'd0, irq_out}, 32'd0);

    // R6 mask keeps pending
    irq_in = 1'b1; tick(4);
    wr(A_ENA, 32'd0); tick();
    chk("R6 masked out", {31'd0, irq_out}, 32'd0);
    rd(A_PEND, rv); chk("R6 mask keeps pend", rv, 32'd1);
    wr(A_ENA, 32'd1);
    chk("R6 out one cycle after enable", {31'd0, irq_out}, 32'd0);
    tick();
    chk("R6 out after enable", {31'd0, irq_out}, 32'd1);

    // R7 edge coincides with ack
    irq_in = 1'b0; tick(4);
    irq_in = 1'b1; tick(2);   // hit active in this cycle
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R7 hit beats ack", rv, 32'd1);
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R7 later ack clears", rv, 32'd0);

    // R4 level high re-sets after ack
    wr(A_MODE, 32'd2); tick();
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R4 high level re-set", rv, 32'd1);
    irq_in = 1'b0; tick(3);
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R4 level gone clears", rv, 32'd0);
    // R4 low level
    wr(A_MODE, 32'd0); tick();
    rd(A_PEND, rv); chk("R4 low level sets", rv, 32'd1);

    // R3 falling edge
    irq_in = 1'b1; wr(A_MODE, 32'd1); tick(3);
    wr(A_PEND, 32'd1);
    rd(A_PEND, rv); chk("R3 falling idle", rv, 32'd0);
    irq_in = 1'b0; tick(3);
    rd(A_PEND, rv); chk("R3 falling edge sets", rv, 32'd1);

    // R8 unmapped offsets and other variant's enable offset
    wr(A_ENA, 32'd0);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(A_ENA, rv);  chk("R8 ena untouched", rv, 32'd0);
    rd(A_MODE, rv); chk("R8 mode untouched", rv, 32'd1);
    rd(8'h34, rv);  chk("R8 other variant offset reads 0", rv, 32'd0);
    rd(8'h0C, rv);  chk("R8 unmapped reads 0", rv, 32'd0);

    // random phase compared against the reference
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) irq_in = ~irq_in;
      bus_wr = 1'b0; bus_wdata = $urandom();
      case (op)
        0: begin bus_wr = 1'b1; bus_addr = A_MODE; end
        1, 2: begin bus_wr = 1'b1; bus_addr = A_PEND; end
        3: begin bus_wr = 1'b1; bus_addr = A_ENA; end
        4: begin bus_wr = 1'b1; bus_addr = 8'($urandom_range(0, 63) * 4); end
        5: bus_addr = A_MODE;
        6: bus_addr = A_ENA;
        default: bus_addr = A_PEND;
      endcase
      #1;
      chk("R6 random irq_out", {31'd0, irq_out}, {31'd0, m_out});
      chk("R3/R4 random read", bus_rdata, f_rd(bus_addr));
      tick();
    end
    bus_wr = 1'b0;
    finish_run();
  end
endmodule